// File: doc/BRIEF.md
# Shared-Generator Multichannel Blink PWM

This block drives up to 33 slow blink or dimming outputs from a small pool of eight waveform generators. Each generator holds three values: a period in units of 4 ms, an on count and an off count. The period is divided into 255 steps. The generator is high for the first on-count steps and low for the off-count steps that follow. Software normally writes the two counts as `d` and `255 - d`.

Every output channel has a 4-bit map entry. The entry holds a 3-bit index that picks one of the generators and an enable bit. A channel that is not enabled is held low. Channels 0 to 15 go straight to pins. Channels 16 to 32 feed a serial shift-out stage that sits outside this block. The serial channels have their own map words. All 33 channel levels leave the block as one registered vector.

Configuration uses a word-wide register port. A write takes effect on the clock edge where `cfg_we` is high. Read data is registered and appears one cycle after the address is presented. The parameter `UNIT_CLKS` sets the number of clocks in one period unit, and it must be at least 255.

Top module: `shared_blink_pwm`

## Requirements
- R1: After reset, `chan_level` is all zero, and every register word reads back as 0.
- R2: The register map uses word addresses.
  - Word 0 holds the periods of generators 0 to 3, and word 1 holds generators 4 to 7. Generator `g` uses byte `g%4`.
  - Words 2 to 5 hold the duty fields. Word `2+g/2` holds generator `g`: bits 15:0 for an even `g` and bits 31:16 for an odd `g`. Within each half, the low byte is the on count and the high byte is the off count.
  - Words 6 to 10 are the map words. Channel `c` sits in word `6+c/8`, nibble `c%8`. In that nibble, bits 2:0 are the index and bit 3 is the enable.
  - Bits with no storage behind them read as 0. Unmapped addresses read 0 and ignore writes.
  - `cfg_rdata` shows the word at `cfg_addr` as sampled on the previous edge.
- R3: Over one full generator cycle, a channel mapped to a generator is high for exactly `on * P * UNIT_CLKS / 255` clocks, where `P` is the generator's period.
- R4: One step lasts `P * UNIT_CLKS / 255` clocks on average, using a fractional accumulator. At the default `UNIT_CLKS` of 255, a full cycle of 255 steps takes `255 * P` clocks.
- R5: A channel level follows the generator named by its current map index. A change of index shows on `chan_level` in the cycle after the write edge.
- R6: A channel whose enable bit is 0 outputs 0 from the cycle after the write edge, whatever its generator does.
- R7: A generator with an on count of 255 and an off count of 0 holds its channels continuously high.
- R8: Any write to a word that holds a generator's period or duty restarts that generator at the start of its on interval. A mapped, enabled channel is then high in the next cycle and stays high for exactly `on * P` clocks at the default `UNIT_CLKS`.
- R9: Channels 16 to 32 are controlled only by map words 8 to 10. Channel 32 uses bits 3:0 of word 10, and the other bits of word 10 read back as 0.
- R10: A generator with an on count of 0 keeps its channels low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous address |
| chan_level | output | NUM_DIRECT+NUM_SERIAL | Registered channel levels, direct channels in the low bits |

## Verification
The generator properties assume two things about the inputs:
- On and off counts change only through register writes. Each such write also restarts the generator's step counter, so a full-on setting is seen from step zero.
- `UNIT_CLKS` is at least 255, so no more than one step is needed in any clock.

The stimulus keeps within these limits in two ways:
- It uses only legal periods between 1 and 5 and duty pairs that sum to 255.
- It keeps a shadow copy of every register word. Each write to a shared word therefore re-sends the current values of the neighbouring generators or channels.

// File: rtl/blink_pwm_pkg.sv
package blink_pwm_pkg;
  localparam int GEN_COUNT  = 8;
  localparam int IDX_W      = 3;
  localparam int WORD_W     = 32;
  localparam int PER_BASE   = 0;
  localparam int DUTY_BASE  = 2;
  localparam int MAP_BASE   = 6;
  localparam int STEPS      = 255;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } chan_map_t;
endpackage

// File: rtl/blink_pwm_regs.sv
module blink_pwm_regs
  import blink_pwm_pkg::*;
#(
  parameter int NUM_CH = 33,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [7:0]        period_o [GEN_COUNT],
  output logic [7:0]        on_o     [GEN_COUNT],
  output logic [7:0]        off_o    [GEN_COUNT],
  output chan_map_t         map_o    [NUM_CH],
  output logic [GEN_COUNT-1:0] restart_o
);
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    for (int g = 0; g < GEN_COUNT; g++) begin
      restart_o[g] = we && ((int'(addr) == PER_BASE + g / 4) ||
                            (int'(addr) == DUTY_BASE + g / 2));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GEN_COUNT; g++) begin
        period_o[g] <= '0;
        on_o[g]     <= '0;
        off_o[g]    <= '0;
      end
      for (int c = 0; c < NUM_CH; c++) map_o[c] <= '0;
    end else if (we) begin
      for (int g = 0; g < GEN_COUNT; g++) begin
        if (int'(addr) == PER_BASE + g / 4)
          period_o[g] <= wdata[8*(g%4) +: 8];
        if (int'(addr) == DUTY_BASE + g / 2) begin
          on_o[g]  <= wdata[16*(g%2) +: 8];
          off_o[g] <= wdata[16*(g%2) + 8 +: 8];
        end
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(addr) == MAP_BASE + c / 8)
          map_o[c] <= wdata[4*(c%8) +: 4];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < GEN_COUNT; g++) begin
      if (int'(addr) == PER_BASE + g / 4)
        rd_word[8*(g%4) +: 8] = period_o[g];
      if (int'(addr) == DUTY_BASE + g / 2)
        rd_word[16*(g%2) +: 16] = {off_o[g], on_o[g]};
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(addr) == MAP_BASE + c / 8)
        rd_word[4*(c%8) +: 4] = map_o[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end
endmodule

// File: rtl/blink_pwm_gen.sv
module blink_pwm_gen
  import blink_pwm_pkg::*;
#(
  parameter int UNIT_CLKS = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [7:0] period,
  input  logic [7:0] on_cnt,
  input  logic [7:0] off_cnt,
  output logic       hi
);
  localparam int ACC_W = $clog2(STEPS * UNIT_CLKS + STEPS + 1) + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] thr;
  logic [8:0]       step_idx;
  logic [8:0]       span;
  logic [8:0]       step_nxt;
  logic             step;

  // one step = period*UNIT_CLKS/255 clocks, carried as a fractional remainder
  assign thr      = ACC_W'(period) * ACC_W'(UNIT_CLKS);
  assign acc_sum  = acc + ACC_W'(STEPS);
  assign step     = acc_sum >= thr;
  assign span     = {1'b0, on_cnt} + {1'b0, off_cnt};
  assign step_nxt = step_idx + 9'd1;
  assign hi       = step_idx < {1'b0, on_cnt};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc      <= '0;
      step_idx <= '0;
    end else if (step) begin
      acc      <= (period == 8'd0) ? '0 : acc_sum - thr;
      step_idx <= (step_nxt >= span) ? 9'd0 : step_nxt;
    end else begin
      acc      <= acc_sum;
    end
  end
endmodule

// File: rtl/shared_blink_pwm.sv
module shared_blink_pwm
  import blink_pwm_pkg::*;
#(
  parameter int NUM_DIRECT = 16,
  parameter int NUM_SERIAL = 17,
  parameter int UNIT_CLKS  = 255,
  parameter int ADDR_W     = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [31:0]                      cfg_wdata,
  output logic [31:0]                      cfg_rdata,
  output logic [NUM_DIRECT+NUM_SERIAL-1:0] chan_level
);
  localparam int NUM_CH = NUM_DIRECT + NUM_SERIAL;

  logic [7:0]           period_cnt [GEN_COUNT];
  logic [7:0]           on_cnt     [GEN_COUNT];
  logic [7:0]           off_cnt    [GEN_COUNT];
  chan_map_t            chan_map   [NUM_CH];
  logic [GEN_COUNT-1:0] restart;
  logic [GEN_COUNT-1:0] gen_hi;

  blink_pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .period_o  (period_cnt),
    .on_o      (on_cnt),
    .off_o     (off_cnt),
    .map_o     (chan_map),
    .restart_o (restart)
  );

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    blink_pwm_gen #(.UNIT_CLKS(UNIT_CLKS)) gen_i (
      .clk     (clk),
      .rst     (rst),
      .restart (restart[g]),
      .period  (period_cnt[g]),
      .on_cnt  (on_cnt[g]),
      .off_cnt (off_cnt[g]),
      .hi      (gen_hi[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) chan_level[c] <= 1'b0;
      else     chan_level[c] <= chan_map[c].en & gen_hi[chan_map[c].idx];
    end
  end
endmodule

// File: rtl/shared_blink_pwm_chk.sv
module shared_blink_pwm_chk
  import blink_pwm_pkg::*;
#(
  parameter int NUM_CH = 33
) (
  input logic                 clk,
  input logic                 rst,
  input logic [GEN_COUNT-1:0] gen_hi,
  input logic [GEN_COUNT-1:0] restart,
  input logic [7:0]           on_cnt  [GEN_COUNT],
  input logic [7:0]           off_cnt [GEN_COUNT],
  input chan_map_t            chan_map [NUM_CH],
  input logic [NUM_CH-1:0]    chan_level
);
  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gchk
    // R7
    a_r7_full_on: assert property (@(posedge clk) disable iff (rst)
      (on_cnt[g] == 8'd255 && off_cnt[g] == 8'd0) |-> gen_hi[g]);
    // R10
    a_r10_zero_on_low: assert property (@(posedge clk) disable iff (rst)
      (on_cnt[g] == 8'd0) |-> !gen_hi[g]);
    // R8
    a_r8_restart_on_phase: assert property (@(posedge clk) disable iff (rst)
      restart[g] |=> (gen_hi[g] || on_cnt[g] == 8'd0));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cchk
    // R6
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !chan_map[c].en |=> !chan_level[c]);
    // R5
    a_r5_select_follows: assert property (@(posedge clk) disable iff (rst)
      chan_map[c].en |=> chan_level[c] == $past(gen_hi[chan_map[c].idx]));
  end
endmodule

bind shared_blink_pwm shared_blink_pwm_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .gen_hi     (gen_hi),
  .restart    (restart),
  .on_cnt     (on_cnt),
  .off_cnt    (off_cnt),
  .chan_map   (chan_map),
  .chan_level (chan_level)
);

// File: tb/shared_blink_pwm_tb_top.sv
`timescale 1ns/1ps
module shared_blink_pwm_tb_top;
  localparam int NCH = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] chan_level;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  logic [7:0] per_sh [8];
  logic [7:0] on_sh  [8];
  logic [7:0] off_sh [8];
  logic [3:0] map_sh [NCH];

  always #2.5 clk = ~clk;

  shared_blink_pwm dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chan_level(chan_level)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 4'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] per_word(input int w);
    return {per_sh[4*w+3], per_sh[4*w+2], per_sh[4*w+1], per_sh[4*w]};
  endfunction

  function automatic logic [31:0] duty_word(input int h);
    return {off_sh[2*h+1], on_sh[2*h+1], off_sh[2*h], on_sh[2*h]};
  endfunction

  function automatic logic [31:0] map_word(input int w);
    logic [31:0] d = '0;
    for (int k = 0; k < 8; k++)
      if (8*w + k < NCH) d[4*k +: 4] = map_sh[8*w+k];
    return d;
  endfunction

  task automatic set_gen(input int g, input int p, input int on, input int off);
    per_sh[g] = 8'(p); on_sh[g] = 8'(on); off_sh[g] = 8'(off);
    wr(g/4, per_word(g/4));
    wr(2 + g/2, duty_word(g/2));
  endtask

  task automatic set_map(input int c, input int idx, input bit en);
    map_sh[c] = {en, 3'(idx)};
    wr(6 + c/8, map_word(c/8));
  endtask

  task automatic count_high(input int c, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (chan_level[c]) n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 levels after reset", longint'(chan_level), 0);
    rd(0, d);  chk("R1 period word reads 0", d, 0);
    rd(3, d);  chk("R1 duty word reads 0", d, 0);
    rd(10, d); chk("R1 map word reads 0", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(1, 32'h0807_0605);
    rd(1, d);  chk("R2 period word 1 readback", d, 32'h0807_0605);
    wr(5, 32'hA1B2_C3D4);
    rd(5, d);  chk("R2 duty word 5 readback", d, 32'hA1B2_C3D4);
    wr(15, 32'hFFFF_FFFF);
    rd(15, d); chk("R2 unmapped address reads 0", d, 0);
    wr(10, 32'hFFFF_FFF3);
    rd(10, d); chk("R9 word 10 keeps only channel 32 nibble", d, 32'h3);
    map_sh[32] = 4'h3;
    for (int g = 4; g < 8; g++) begin per_sh[g] = 8'd1; on_sh[g] = 8'd0; off_sh[g] = 8'd255; end
    wr(1, per_word(1)); wr(4, duty_word(2)); wr(5, duty_word(3));
  endtask

  task automatic t_duty();
    int n;
    set_map(0, 0, 1'b1);
    set_gen(0, 1, 64, 191);
    count_high(0, 255, n);
    chk("R3 gen0 highs per cycle", n, 64);
    count_high(0, 510, n);
    chk("R3 gen0 highs over two cycles", n, 128);
  endtask

  task automatic t_period_restart();
    int n, run;
    bit seen_low;
    set_map(1, 1, 1'b1);
    set_gen(1, 3, 100, 155);
    run = 0; seen_low = 1'b0;
    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      if (!seen_low && chan_level[1]) run++;
      else seen_low = 1'b1;
    end
    chk("R8 high run after restart", run, 300);
    count_high(1, 765, n);
    chk("R4 gen1 period 3 highs per cycle", n, 300);
    set_gen(1, 2, 10, 245);
    count_high(1, 510, n);
    chk("R4 gen1 period 2 highs per cycle", n, 20);
  endtask

  task automatic t_full_zero();
    int n;
    set_gen(2, 5, 255, 0);
    set_gen(3, 2, 0, 255);
    set_map(3, 3, 1'b1);
    set_map(4, 2, 1'b1);
    count_high(4, 600, n);
    chk("R7 full-on channel all high", n, 600);
    count_high(3, 600, n);
    chk("R10 zero-on channel all low", n, 0);
  endtask

  task automatic t_select_disable();
    int n;
    set_map(2, 0, 1'b1);
    set_map(2, 2, 1'b1);
    @(negedge clk);
    chk("R5 switch to full-on gen next cycle", chan_level[2], 1);
    set_map(2, 3, 1'b1);
    @(negedge clk);
    chk("R5 switch to zero gen next cycle", chan_level[2], 0);
    set_map(2, 2, 1'b1);
    set_map(2, 2, 1'b0);
    @(negedge clk);
    chk("R6 disabled channel low next cycle", chan_level[2], 0);
    count_high(2, 100, n);
    chk("R6 disabled channel stays low", n, 0);
  endtask

  task automatic t_serial();
    logic [31:0] d;
    set_map(32, 2, 1'b1);
    @(negedge clk);
    chk("R9 channel 32 follows word 10", chan_level[32], 1);
    rd(10, d);
    chk("R9 word 10 readback", d, 32'hA);
    set_map(16, 2, 1'b1);
    @(negedge clk);
    chk("R9 channel 16 follows word 8", chan_level[16], 1);
    chk("R9 direct channel 4 unchanged", chan_level[4], 1);
    chk("R9 channel 17 still off", chan_level[17], 0);
  endtask

  initial begin
    for (int g = 0; g < 8; g++) begin per_sh[g] = '0; on_sh[g] = '0; off_sh[g] = '0; end
    for (int c = 0; c < NCH; c++) map_sh[c] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_duty();
    t_period_restart();
    t_full_zero();
    t_select_disable();
    t_serial();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule